// File: doc/BRIEF.md
# Bidirectional GPIO Port with Timer Compare Override

This block is an eight-pin general purpose I/O port on a simple register bus. Each pad is modelled as three signals: the level arriving from the pin, the level to drive, and an output enable. Software sets each pin's direction and output level through two writable registers. A third register is read-only and returns the synchronized level seen on every pin, whatever that pin's direction.

A timer sits next to the port and provides a per-pin compare enable and compare level. While a pin's compare enable is high, the pin drives the timer's level whatever its stored direction bit says. The stored direction bit is neither set nor cleared by this. When the enable drops, the direction bit controls the pin again. The synchronized pin level is always passed to the timer's capture logic. Reading the pin register while a pin is driven therefore shows whether the pad really holds the intended level, which reveals a shorted or overloaded output.

Top module: `gpio_timer_port`

## Requirements
- R1: After reset the output data register (offset 0) and the direction register (offset 2) read 0x00, and every pad_oe bit is 0. Reset does not alter the pin register (offset 1), which keeps showing the pins.
- R2: A write strobe with bus_addr = 2 loads bus_wdata into the direction register at the next rising clock edge. The new value reads back at offset 2.
- R3: With no timer override, a direction bit of 1 sets that pad_oe bit to 1 and a direction bit of 0 sets it to 0 (high-impedance input). pad_out carries the output data register bit.
- R4: Offset 1 returns pad_in through a two-flop synchronizer. A pin change shows up after exactly two rising edges, in both input and output direction.
- R5: A write to offset 1 has no effect. The data and direction registers keep their values and offset 1 still shows the pins.
- R6: While tmr_oc_en[i] is 1, pad_oe[i] is 1 and pad_out[i] equals tmr_oc_lvl[i], whatever the direction bit.
- R7: A timer override leaves the stored direction bit unchanged, and the bit can still be written during the override. When tmr_oc_en[i] returns to 0, pad_oe[i] again follows the stored bit.
- R8: tmr_cap always equals the value that offset 1 returns, for pins in both input and output mode.
- R9: Offset 3 reads 0x00. A write to offset 3 changes no register.
- R10: A write strobe with bus_addr = 0 loads bus_wdata into the output data register at the next rising edge. The value reads back at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 8 | Level arriving from the pins |
| pad_out | output | 8 | Level to drive on the pins |
| pad_oe | output | 8 | Per-pin output enable |
| tmr_oc_en | input | 8 | Per-pin timer compare enable (override) |
| tmr_oc_lvl | input | 8 | Per-pin timer compare output level |
| tmr_cap | output | 8 | Synchronized pin levels for timer capture |

## Verification
A corrupted direction or data register shows up at pad_oe or pad_out in the cycle after the write, and at the matching read offset at the same moment. An override that leaked into the stored direction bits stays hidden while the timer drives the pin. It surfaces only when the override is released, or when offset 2 is read during the override, so the bench reads both at those moments. A wrong synchronizer depth makes the pin register and tmr_cap change one edge early or late, so the bench samples that path one edge and two edges after a pin change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_PIN  = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 2'd2;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync
);
    localparam int CW = $clog2(STAGES + 1);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    // Synchronizer flops carry no reset: they only mirror the pins.
    always_comb begin
        chain_d[0] = pin_raw;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign pin_sync = chain_q[STAGES-1];

    // Warm-up count since reset, used only to bound the look-back below.
    logic [CW-1:0] warm_d, warm_q;
    always_comb begin
        warm_d = warm_q;
        if (warm_q != CW'(STAGES)) warm_d = warm_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    p_sync_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == CW'(STAGES)) |-> (pin_sync == $past(pin_raw, STAGES)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q
);
    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                OFS_DATA: r_d.data = wr_data;
                OFS_DIR:  r_d.dir  = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_q = r_q.data;
    assign dir_q  = r_q.dir;

    // R5 / R9: only the matching offset may change a stored register.
    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == OFS_DATA) |=> $stable(data_q));
    // R7: the direction register changes only by a bus write, never by override.
    p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == OFS_DIR) |=> $stable(dir_q));
    p_data_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_DATA) |=> (data_q == $past(wr_data)));
    p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_DIR) |=> (dir_q == $past(wr_data)));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] oc_en,
    input  logic [W-1:0] oc_lvl,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            pad_oe[i]  = dir_q[i] | oc_en[i];
            pad_out[i] = oc_en[i] ? oc_lvl[i] : data_q[i];
        end

        // R7: after the override ends the stored bit decides again.
        p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(oc_en[i]) |-> (pad_oe[i] == dir_q[i] && pad_out[i] == data_q[i]));
        // R6: a forced pin drives the compare level.
        p_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
            oc_en[i] |-> (pad_oe[i] && pad_out[i] == oc_lvl[i]));
    end
endmodule

// File: rtl/gpio_timer_port.sv
module gpio_timer_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    input  logic [WIDTH-1:0]  tmr_oc_en,
    input  logic [WIDTH-1:0]  tmr_oc_lvl,
    output logic [WIDTH-1:0]  tmr_cap
);
    logic [WIDTH-1:0] data_q, dir_q, pin_q;

    gpio_pin_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pad_in),
        .pin_sync (pin_q)
    );

    gpio_port_regs #(.W(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .data_q  (data_q),
        .dir_q   (dir_q)
    );

    gpio_pad_mux #(.W(WIDTH)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .oc_en   (tmr_oc_en),
        .oc_lvl  (tmr_oc_lvl),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign tmr_cap = pin_q;

    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = data_q;
            OFS_PIN:  bus_rdata = pin_q;
            OFS_DIR:  bus_rdata = dir_q;
            default:  bus_rdata = '0;
        endcase
    end

    p_pin_eq_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_PIN) |-> (bus_rdata == tmr_cap));
    p_idle_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));
    p_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_oc_en == '0) |-> ((pad_oe & ~pad_out) == (pad_oe & ~data_q)));
endmodule

// File: tb/test_gpio_timer_port.sv
module test_gpio_timer_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe;
    logic [7:0] tmr_oc_en = '0;
    logic [7:0] tmr_oc_lvl = '0;
    logic [7:0] tmr_cap;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_timer_port i_gpio_timer_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .tmr_oc_en(tmr_oc_en),
        .tmr_oc_lvl(tmr_oc_lvl), .tmr_cap(tmr_cap)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] waddr;
        logic [7:0] wdata;
        logic [7:0] pad;
        logic [7:0] oc_en;
        logic [7:0] oc_lvl;
        logic [1:0] raddr;
        logic [7:0] exp_rd;
        logic [7:0] exp_oe;
        logic [7:0] exp_out;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // R2: direction write
        '{1'b1, 2'd2, 8'hF0, 8'h5A, 8'h00, 8'h00, 2'd2, 8'hF0, 8'hF0, 8'h00, 4'd2},
        // R10 / R3: data write, upper nibble driven
        '{1'b1, 2'd0, 8'hC3, 8'h5A, 8'h00, 8'h00, 2'd0, 8'hC3, 8'hF0, 8'hC3, 4'd10},
        // R5: write to pin register ignored, pins shown
        '{1'b1, 2'd1, 8'hFF, 8'h3C, 8'h00, 8'h00, 2'd1, 8'h3C, 8'hF0, 8'hC3, 4'd5},
        // R5: data unchanged after that write
        '{1'b0, 2'd0, 8'h00, 8'h3C, 8'h00, 8'h00, 2'd0, 8'hC3, 8'hF0, 8'hC3, 4'd5},
        // R6 / R7: override low nibble, direction readback unchanged
        '{1'b0, 2'd0, 8'h00, 8'h3C, 8'h0F, 8'h05, 2'd2, 8'hF0, 8'hFF, 8'hC5, 4'd6},
        // R7: direction written during override
        '{1'b1, 2'd2, 8'h00, 8'h3C, 8'h0F, 8'h05, 2'd2, 8'h00, 8'h0F, 8'hC5, 4'd7},
        // R7: override released, stored bits rule
        '{1'b0, 2'd0, 8'h00, 8'h3C, 8'h00, 8'h05, 2'd2, 8'h00, 8'h00, 8'hC3, 4'd7},
        // R9: offset 3 reads zero
        '{1'b1, 2'd3, 8'hAA, 8'h3C, 8'h00, 8'h00, 2'd3, 8'h00, 8'h00, 8'hC3, 4'd9},
        // R9: offset 3 write left data alone
        '{1'b0, 2'd0, 8'h00, 8'h3C, 8'h00, 8'h00, 2'd0, 8'hC3, 8'h00, 8'hC3, 4'd9},
        // R4: pins visible with all outputs
        '{1'b1, 2'd2, 8'hFF, 8'hA5, 8'h00, 8'h00, 2'd1, 8'hA5, 8'hFF, 8'hC3, 4'd4}
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic read_at(input logic [1:0] a);
        bus_addr = a;
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        read_at(2'd0); check("R1", "data after reset", bus_rdata, 8'h00);
        read_at(2'd2); check("R1", "dir after reset", bus_rdata, 8'h00);
        check("R1", "oe after reset", pad_oe, 8'h00);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[v].req);
            @(negedge clk);
            bus_wr     = VECS[v].wr;
            bus_addr   = VECS[v].waddr;
            bus_wdata  = VECS[v].wdata;
            pad_in     = VECS[v].pad;
            tmr_oc_en  = VECS[v].oc_en;
            tmr_oc_lvl = VECS[v].oc_lvl;
            @(negedge clk);
            bus_wr = 1'b0;
            repeat (2) @(negedge clk);
            read_at(VECS[v].raddr);
            check(tag, $sformatf("vec %0d rdata", v), bus_rdata, VECS[v].exp_rd);
            check(tag, $sformatf("vec %0d oe", v), pad_oe, VECS[v].exp_oe);
            check(tag, $sformatf("vec %0d out", v), pad_out, VECS[v].exp_out);
            check("R8", $sformatf("vec %0d cap", v), tmr_cap, VECS[v].pad);
        end

        // R4: exact two-edge latency, R8: capture path tracks it
        @(negedge clk);
        pad_in = 8'h69;
        @(negedge clk);
        read_at(2'd1);
        check("R4", "pin after one edge", bus_rdata, 8'hA5);
        @(negedge clk);
        read_at(2'd1);
        check("R4", "pin after two edges", bus_rdata, 8'h69);
        check("R8", "cap after two edges", tmr_cap, 8'h69);

        // R6: override with direction set, level follows timer
        tmr_oc_en = 8'hFF;
        tmr_oc_lvl = 8'h96;
        #1;
        check("R6", "forced level", pad_out, 8'h96);
        check("R6", "forced oe", pad_oe, 8'hFF);
        @(negedge clk);
        tmr_oc_en = 8'h00;

        // R1: reset mid-run clears registers, pin register still shows pins
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        read_at(2'd2); check("R1", "dir in reset", bus_rdata, 8'h00);
        read_at(2'd1); check("R1", "pin unaffected by reset", bus_rdata, 8'h69);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_at(2'd0); check("R1", "data after reset", bus_rdata, 8'h00);
        check("R1", "oe after reset", pad_oe, 8'h00);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule